// File: doc/BRIEF.md
# Halt Wakeup Controller

This block controls the deepest low-power state of a small microcontroller. The CPU strobes a halt request. If the watchdog is disabled, the controller gates off the oscillator, the CPU clock and the peripheral clock together. It also clears the interrupt-mask bit, so that an external interrupt can bring the part back. If the watchdog is enabled, the request is refused and turned into a one-cycle watchdog reset request that resets the whole MCU.

While halted, only two events end the state: an external interrupt, taken through a two-flop synchronizer on the free-running reference clock, or the reset input. On a wakeup, the oscillator enable returns first. The CPU and peripheral clocks stay gated for a fixed settling window of 4096 reference cycles. They are then released together with the mask bit set, and a one-cycle cause pulse tells the CPU either to fetch the reset vector or to service the waking interrupt. Reset has priority over an interrupt that arrives in the same cycle.

The reset input is active high and sampled on the reference clock. Outside the halt sequence it forces the run state. During the halt sequence it acts as a wakeup source.

Top module: `halt_wake_ctl`

## Requirements
- R1: A halt request sampled in the run state while `wdg_en` is 1 does not halt. On the next cycle `wdg_rst_req` is 1 for that single cycle, and all clock enables stay 1.
- R2: A halt request sampled in the run state while `wdg_en` is 0 drives `osc_en`, `cpu_clk_en` and `per_clk_en` to 0 together on the next cycle.
- R3: In that same cycle of halt entry, `irq_mask` goes to 0.
- R4: While halted, `halt_req` and `wdg_en` have no effect. All three clock enables remain 0 until a synchronized interrupt or reset is seen.
- R5: The cycle after a wakeup event is seen, `osc_en` is 1 while `cpu_clk_en` and `per_clk_en` stay 0 for exactly SETTLE_CYCLES (default 4096) cycles.
- R6: After the settling window, `cpu_clk_en` and `per_clk_en` rise together in the same cycle, and `irq_mask` is 1 in that cycle.
- R7: In the first cycle with the clocks released, `wake_rst_vec` is 1 if reset caused the wakeup, or `wake_irq_svc` is 1 if the interrupt did. Exactly one of the two is set.
- R8: Each cause output is a one-cycle pulse. If reset and the synchronized interrupt are seen in the same cycle, the cause is reset.
- R9: `ext_irq` passes through two reference-clock flops. A line rising just after an edge gives `osc_en` = 1 three edges later. Outside the halted state the line has no effect on any output.
- R10: Reset in the run state gives, on the next cycle, all clock enables 1, `irq_mask` 1 and no pulses. Reset in the halted state starts the settling window with the reset cause. Reset during the settling window restarts the full window with the reset cause.
- R11: A halt request during the settling window is ignored: no halt, no watchdog reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Active-high reset, synchronous; also a wakeup source |
| halt_req | input | 1 | Halt request strobe from the CPU |
| wdg_en | input | 1 | Watchdog enabled flag |
| ext_irq | input | 1 | External interrupt line, asynchronous |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| irq_mask | output | 1 | Interrupt-mask bit |
| wake_rst_vec | output | 1 | One-cycle pulse: fetch reset vector |
| wake_irq_svc | output | 1 | One-cycle pulse: service the waking interrupt |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Each result has a fixed latency. The gates and mask respond one edge after a halt request. The watchdog request is due one edge after the refused request. `osc_en` rises one edge after a reset wake and three edges after an interrupt line rise. The clock release comes 4096 edges after the oscillator restart, with the cause pulse in that same cycle and cleared one cycle later. The bench drives inputs and samples outputs at falling edges, and counts the settling window cycle by cycle instead of waiting a fixed time, so an early or late release shows up as a count mismatch.

// File: rtl/halt_ctl_pkg.sv
`timescale 1ns/1ps
package halt_ctl_pkg;

    localparam int unsigned DEF_SETTLE_CYCLES = 4096;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_HALTED = 2'd1,
        PM_SETTLE = 2'd2,
        PM_SPARE  = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_RESET = 2'd1,
        WK_IRQ   = 2'd2
    } wake_src_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
    } clk_gate_t;

    typedef struct packed {
        logic rst_vec;
        logic irq_svc;
        logic wdg_rst;
    } pm_pulse_t;

    // Clock gate pattern per state: oscillator first, CPU and peripherals only in run.
    function automatic clk_gate_t gates_for(input pm_state_e st);
        clk_gate_t g;
        case (st)
            PM_HALTED: g = '{osc: 1'b0, cpu: 1'b0, per: 1'b0};
            PM_SETTLE: g = '{osc: 1'b1, cpu: 1'b0, per: 1'b0};
            default:   g = '{osc: 1'b1, cpu: 1'b1, per: 1'b1};
        endcase
        return g;
    endfunction

    // Reset outranks an interrupt seen in the same cycle.
    function automatic wake_src_e pick_source(input logic rst_seen, input logic irq_seen);
        if (rst_seen)      return WK_RESET;
        else if (irq_seen) return WK_IRQ;
        else               return WK_NONE;
    endfunction

endpackage

// File: rtl/halt_irq_sync.sv
`timescale 1ns/1ps
module halt_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/halt_settle_timer.sv
`timescale 1ns/1ps
module halt_settle_timer #(
    parameter int unsigned CYCLES = 4096
) (
    input  logic clk,
    input  logic load,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Loaded together with the move into settling; counts down to zero and rests there.
    always_ff @(posedge clk) begin
        if (load)              cnt_q <= RELOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/halt_pm_fsm.sv
`timescale 1ns/1ps
module halt_pm_fsm
    import halt_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      wdg_en,
    input  logic      irq_s,
    input  logic      tmr_done,
    output logic      tmr_load,
    output pm_state_e state,
    output logic      mask,
    output pm_pulse_t pulses
);
    pm_state_e st_q;
    wake_src_e src_q;
    logic      mask_q;
    pm_pulse_t pls_q;
    logic      wake_evt;
    logic      restart;

    assign wake_evt = (st_q == PM_HALTED) && (rst || irq_s);
    assign restart  = (st_q == PM_SETTLE) && rst;
    assign tmr_load = wake_evt || restart;

    always_ff @(posedge clk) begin
        pls_q <= '0;
        case (st_q)
            PM_HALTED: begin
                if (wake_evt) begin
                    st_q  <= PM_SETTLE;
                    src_q <= pick_source(rst, irq_s);
                end
            end
            PM_SETTLE: begin
                if (rst) begin
                    src_q <= WK_RESET;
                end else if (tmr_done) begin
                    st_q          <= PM_RUN;
                    mask_q        <= 1'b1;
                    pls_q.rst_vec <= (src_q == WK_RESET);
                    pls_q.irq_svc <= (src_q == WK_IRQ);
                    src_q         <= WK_NONE;
                end
            end
            default: begin
                if (rst) begin
                    st_q   <= PM_RUN;
                    mask_q <= 1'b1;
                    src_q  <= WK_NONE;
                end else if (halt_req) begin
                    if (wdg_en) begin
                        pls_q.wdg_rst <= 1'b1;
                    end else begin
                        st_q   <= PM_HALTED;
                        mask_q <= 1'b0;
                    end
                end
            end
        endcase
    end

    assign state  = st_q;
    assign mask   = mask_q;
    assign pulses = pls_q;
endmodule

// File: rtl/halt_wake_ctl.sv
`timescale 1ns/1ps
module halt_wake_ctl
    import halt_ctl_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = DEF_SETTLE_CYCLES,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic wdg_en,
    input  logic ext_irq,
    output logic osc_en,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic irq_mask,
    output logic wake_rst_vec,
    output logic wake_irq_svc,
    output logic wdg_rst_req
);
    logic      irq_s;
    logic      tmr_load;
    logic      tmr_done;
    pm_state_e state;
    pm_pulse_t pulses;
    clk_gate_t gates;

    halt_irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_irq),
        .sync_out (irq_s)
    );

    halt_settle_timer #(.CYCLES(SETTLE_CYCLES)) timer_i (
        .clk  (clk),
        .load (tmr_load),
        .done (tmr_done)
    );

    halt_pm_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .halt_req (halt_req),
        .wdg_en   (wdg_en),
        .irq_s    (irq_s),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .state    (state),
        .mask     (irq_mask),
        .pulses   (pulses)
    );

    assign gates        = gates_for(state);
    assign osc_en       = gates.osc;
    assign cpu_clk_en   = gates.cpu;
    assign per_clk_en   = gates.per;
    assign wake_rst_vec = pulses.rst_vec;
    assign wake_irq_svc = pulses.irq_svc;
    assign wdg_rst_req  = pulses.wdg_rst;
endmodule

// File: rtl/halt_wake_ctl_chk.sv
`timescale 1ns/1ps
module halt_wake_ctl_chk #(
    parameter int unsigned SETTLE_CYCLES = 4096
) (
    input logic clk,
    input logic rst,
    input logic halt_req,
    input logic wdg_en,
    input logic irq_s,
    input logic osc_en,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic irq_mask,
    input logic wake_rst_vec,
    input logic wake_irq_svc,
    input logic wdg_rst_req
);
    localparam int unsigned KW = $clog2(SETTLE_CYCLES + 1) + 1;

    logic [KW-1:0] hold_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !osc_en || cpu_clk_en) hold_cnt_q <= '0;
        else                              hold_cnt_q <= hold_cnt_q + 1'b1;
    end

    AST_WDG_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (halt_req && wdg_en && cpu_clk_en) |=> (wdg_rst_req && cpu_clk_en && osc_en)); // R1
    AST_WDG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_req |-> $past(halt_req && wdg_en)); // R1
    AST_HALT_GATES: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !wdg_en && cpu_clk_en) |=> (!osc_en && !cpu_clk_en && !per_clk_en)); // R2
    AST_HALT_MASK: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !wdg_en && cpu_clk_en) |=> !irq_mask); // R3
    AST_HALT_STAY: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !irq_s) |=> !osc_en); // R4
    AST_OSC_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> (!cpu_clk_en && !per_clk_en)); // R5
    AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (hold_cnt_q == KW'(SETTLE_CYCLES))); // R5
    AST_RELEASE_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (per_clk_en && irq_mask)); // R6
    AST_CAUSE_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (wake_rst_vec ^ wake_irq_svc)); // R7
    AST_RVEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake_rst_vec |=> !wake_rst_vec); // R8
    AST_ISVC_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake_irq_svc |=> !wake_irq_svc); // R8
    AST_SETTLE_NO_HALT: assert property (@(posedge clk) disable iff (rst)
        (osc_en && !cpu_clk_en && halt_req) |=> (osc_en && !wdg_rst_req)); // R11
endmodule

bind halt_wake_ctl halt_wake_ctl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .halt_req     (halt_req),
    .wdg_en       (wdg_en),
    .irq_s        (irq_s),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .irq_mask     (irq_mask),
    .wake_rst_vec (wake_rst_vec),
    .wake_irq_svc (wake_irq_svc),
    .wdg_rst_req  (wdg_rst_req)
);

// File: tb/halt_wake_ctl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctl_tb_top;
    localparam int SETTLE = 4096;
    localparam int SYNC_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 1'b0;
    logic wdg_en = 1'b0;
    logic ext_irq = 1'b0;
    logic osc_en, cpu_clk_en, per_clk_en, irq_mask;
    logic wake_rst_vec, wake_irq_svc, wdg_rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    halt_wake_ctl dut_i (
        .clk          (clk),
        .rst          (rst),
        .halt_req     (halt_req),
        .wdg_en       (wdg_en),
        .ext_irq      (ext_irq),
        .osc_en       (osc_en),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .irq_mask     (irq_mask),
        .wake_rst_vec (wake_rst_vec),
        .wake_irq_svc (wake_irq_svc),
        .wdg_rst_req  (wdg_rst_req)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected cause pulses {rst_vec, irq_svc}: reset wins.
    function automatic logic [1:0] exp_cause(input bit by_rst, input bit by_irq);
        if (by_rst)      return 2'b10;
        else if (by_irq) return 2'b01;
        else             return 2'b00;
    endfunction

    function automatic logic [2:0] gates_now();
        return {osc_en, cpu_clk_en, per_clk_en};
    endfunction

    task automatic enter_halt();
        halt_req = 1'b1; wdg_en = 1'b0;
        tick();
        halt_req = 1'b0;
        chk("R2 gates off on halt", gates_now(), 3'b000);
        chk("R3 mask cleared on halt", irq_mask, 0);
    endtask

    task automatic refused_halt();
        halt_req = 1'b1; wdg_en = 1'b1;
        tick();
        halt_req = 1'b0; wdg_en = 1'b0;
        chk("R1 watchdog reset request", wdg_rst_req, 1);
        chk("R1 clocks stay on", gates_now(), 3'b111);
        tick();
        chk("R1 request is one cycle", wdg_rst_req, 0);
    endtask

    task automatic halted_noise(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            halt_req = 1'($urandom);
            wdg_en   = 1'($urandom);
            tick();
            chk("R4 stays halted", gates_now(), 3'b000);
        end
        halt_req = 1'b0; wdg_en = 1'b0;
    endtask

    task automatic run_noise(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            ext_irq = 1'($urandom);
            tick();
            chk("R9 line ignored in run", {gates_now(), wake_rst_vec, wake_irq_svc}, 5'b11100);
        end
        ext_irq = 1'b0;
        tick(SYNC_LAT);
    endtask

    task automatic wake_by_irq();
        int n = 0;
        ext_irq = 1'b1;
        while (!osc_en && n < 20) begin
            tick();
            n++;
        end
        ext_irq = 1'b0;
        chk("R9 synchronizer latency", n, SYNC_LAT);
        chk("R5 oscillator first", {cpu_clk_en, per_clk_en}, 2'b00);
    endtask

    task automatic wake_by_rst();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R10 reset wakes from halt", gates_now(), 3'b100);
    endtask

    task automatic wake_by_both();
        ext_irq = 1'b1;
        tick(SYNC_LAT - 1);
        rst = 1'b1;
        tick();
        rst = 1'b0; ext_irq = 1'b0;
        chk("R8 simultaneous wake", gates_now(), 3'b100);
    endtask

    task automatic finish_wake(input bit by_rst, input bit by_irq);
        int n = 0;
        int bad = 0;
        while (!cpu_clk_en && n < 3 * SETTLE) begin
            if (!osc_en || per_clk_en) bad++;
            tick();
            n++;
        end
        chk("R5 settle length", n, SETTLE);
        chk("R5 gates during settle", bad, 0);
        chk("R6 release together", {per_clk_en, irq_mask}, 2'b11);
        chk("R7 wake cause", {wake_rst_vec, wake_irq_svc}, exp_cause(by_rst, by_irq));
        tick();
        chk("R8 cause is one cycle", {wake_rst_vec, wake_irq_svc}, 2'b00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        chk("R10 reset state", {gates_now(), irq_mask}, 4'b1111);
        chk("R10 no pulses in reset", {wake_rst_vec, wake_irq_svc, wdg_rst_req}, 3'b000);
        rst = 1'b0;
        tick(2);

        // Directed: refused halt, then interrupt wake.
        refused_halt();
        enter_halt();
        halted_noise(8);
        wake_by_irq();
        finish_wake(1'b0, 1'b1);

        // Directed: reset wake.
        enter_halt();
        wake_by_rst();
        finish_wake(1'b1, 1'b0);

        // Directed: reset and interrupt together.
        enter_halt();
        wake_by_both();
        finish_wake(1'b1, 1'b1);

        // Directed: halt request during settle ignored, then reset restarts the window.
        enter_halt();
        wake_by_irq();
        tick(100);
        halt_req = 1'b1; wdg_en = 1'b1;
        tick();
        halt_req = 1'b0; wdg_en = 1'b0;
        chk("R11 no watchdog request in settle", wdg_rst_req, 0);
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        chk("R11 halt ignored in settle", gates_now(), 3'b100);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R10 reset restarts settle", gates_now(), 3'b100);
        finish_wake(1'b1, 1'b0);

        // Directed: reset in run.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R10 reset in run", {gates_now(), irq_mask}, 4'b1111);

        // Constrained random scenarios.
        for (int it = 0; it < 20; it++) begin
            int src;
            run_noise(int'($urandom_range(0, 6)));
            if ($urandom_range(0, 1) == 1) refused_halt();
            enter_halt();
            halted_noise(int'($urandom_range(0, 12)));
            src = int'($urandom_range(0, 2));
            case (src)
                0: begin wake_by_irq();  finish_wake(1'b0, 1'b1); end
                1: begin wake_by_rst();  finish_wake(1'b1, 1'b0); end
                default: begin wake_by_both(); finish_wake(1'b1, 1'b1); end
            endcase
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule